// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block performs one bus cycle on an 8-bit asynchronous NAND flash interface for each request from a host. A request gives the cycle kind (command, address or data), a direction bit, a target bank and a byte. The sequencer then walks the bus through its phases: an optional bus-release window on writes, address setup, an optional read turnaround, the strobe, and the hold. It drives the chip enables, the command and address latch enables, the read and write strobes and the output enable of the tristate data bus.

Each phase has its own length, taken from six timing inputs sampled when the request is accepted. One down-counter, reloaded on each phase entry, times every phase. The strobe is stretched for as long as the device holds its wait input low. On reads the byte on the data bus is captured on the clock edge that ends the strobe. A one-cycle done pulse marks the end of every access. Requests are taken only while the sequencer is idle.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset all four chip enables, `re_n` and `we_n` are high, `cle`, `ale`, `dq_oe`, `done` and `busy` are low, and `rd_data` is zero.
- R2: From the cycle after acceptance until the last hold cycle, exactly `ce_n[b]` is low, where b is the accepted `req_bank` (bit i serves bank i). At all other times every chip enable is high.
- R3: `req_kind` 0 is a command cycle and raises `cle`. Value 1 is an address cycle and raises `ale`. Values 2 and 3 are data cycles and raise neither. The selected line stays high from the first access cycle through the last hold cycle.
- R4: The setup phase lasts `cfg_setup`+1 cycles, and no strobe is asserted during it.
- R5: On a write with `cfg_hiz`=N, the first N access cycles leave `dq_oe` low. N=0 means no such cycles. `dq_oe` is then high until the last hold cycle. On reads `dq_oe` stays low and `cfg_hiz` has no effect.
- R6: The strobe (`re_n` on reads, `we_n` on writes) is low for `cfg_wait`+1 cycles. It is then extended by one cycle for each clock edge on which the strobe is low and `dev_wait_n` is low.
- R7: After the strobe rises, a hold phase of `cfg_hold`+1 cycles keeps the chip enable, `cle`/`ale` and, on writes, `dq_oe` active.
- R8: A read that directly follows a command access waits `cfg_cle_dly`+1 extra cycles between setup and strobe. A read that follows an address access waits `cfg_ale_dly`+1 extra cycles. A read that follows a data access, or the first read after reset, waits no extra cycles.
- R9: While `dq_oe` is high, `dq_out` equals the accepted byte. On a read, `rd_data` takes the value `dq_in` had at the clock edge on which `re_n` rises, and it keeps that value until the next read capture.
- R10: `done` is high for exactly one cycle, which follows the last hold cycle and has every strobe and enable inactive. The next cycle is idle.
- R11: `busy` is high from the cycle after acceptance through the done cycle. `req_valid` is ignored while `busy` is high.
- R12: The timing inputs are sampled at acceptance. Changing them during an access does not change that access's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank whose chip enable is driven |
| req_byte | input | 8 | Byte to place on the bus for writes |
| cfg_cle_dly | input | 4 | Read turnaround after a command access, N+1 cycles |
| cfg_ale_dly | input | 4 | Read turnaround after an address access, N+1 cycles |
| cfg_hiz | input | 8 | Bus-release cycles at the start of a write, N cycles |
| cfg_hold | input | 8 | Hold after strobe, N+1 cycles |
| cfg_wait | input | 8 | Strobe width, N+1 cycles |
| cfg_setup | input | 8 | Setup before strobe, N+1 cycles |
| dev_wait_n | input | 1 | Device wait, low stretches the strobe |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| ce_n | output | 4 | Active-low chip enables, one per bank |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| re_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| rd_data | output | 8 | Byte captured by the last read |
| done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access in progress |

## Verification
The properties assume that `dev_wait_n` is a clean synchronous level and that the device eventually raises it. If it never does, the stretched strobe never ends. The bench controls the wait input per cycle and always releases it after a known number of extra cycles. The properties also assume that `req_kind` is one of its defined codes and that `dq_in` is valid on the capture edge. The bench holds `dq_in` at the expected byte up to that edge and inverts it right after, so a capture one cycle late shows. The bench also sends a second request partway through each access, and it scrambles the timing inputs straight after acceptance, to exercise the inputs the design must ignore.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIZ,
        ST_SETUP,
        ST_TURN,
        ST_STROBE,
        ST_WAIT,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } cycle_kind_e;

    function automatic cycle_kind_e decode_kind(input logic [1:0] code);
        case (code)
            2'd0:    return KIND_CMD;
            2'd1:    return KIND_ADDR;
            default: return KIND_DATA;
        endcase
    endfunction

endpackage

// File: rtl/nand_phase_counter.sv
module nand_phase_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_bank_decode.sv
module nand_bank_decode #(
    parameter int NBANKS = 4,
    localparam int BANK_W = $clog2(NBANKS)
) (
    input  logic              enable,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANKS-1:0] ce_n
);
    for (genvar i = 0; i < NBANKS; i++) begin : g_ce
        assign ce_n[i] = !(enable && (bank == BANK_W'(i)));
    end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
    parameter int DATA_W  = 8,
    parameter int NBANKS  = 4,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 8,
    localparam int BANK_W = $clog2(NBANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [DATA_W-1:0] req_byte,
    input  logic [SHORT_W-1:0] cfg_cle_dly,
    input  logic [SHORT_W-1:0] cfg_ale_dly,
    input  logic [LONG_W-1:0] cfg_hiz,
    input  logic [LONG_W-1:0] cfg_hold,
    input  logic [LONG_W-1:0] cfg_wait,
    input  logic [LONG_W-1:0] cfg_setup,
    input  logic              dev_wait_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [NBANKS-1:0] ce_n,
    output logic              cle,
    output logic              ale,
    output logic              re_n,
    output logic              we_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);
    import nand_seq_pkg::*;

    localparam int PAD_W = LONG_W - SHORT_W;

    typedef struct packed {
        seq_state_e          st;
        logic                write;
        cycle_kind_e         kind;
        cycle_kind_e         prev;
        logic [BANK_W-1:0]   bank;
        logic [DATA_W-1:0]   wbyte;
        logic [DATA_W-1:0]   rbyte;
        logic [LONG_W-1:0]   setup;
        logic [LONG_W-1:0]   strobe;
        logic [LONG_W-1:0]   hold;
        logic                turn;
        logic [LONG_W-1:0]   turn_len;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              cnt_load;
    logic [LONG_W-1:0] cnt_val;
    logic              cnt_zero;
    logic              active;
    logic              strobe_on;

    nand_phase_counter #(.W(LONG_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_zero)
    );

    // Next-state and datapath for the whole sequencer.
    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.write  = req_write;
                    r_d.kind   = decode_kind(req_kind);
                    r_d.prev   = decode_kind(req_kind);
                    r_d.bank   = req_bank;
                    r_d.wbyte  = req_byte;
                    r_d.setup  = cfg_setup;
                    r_d.strobe = cfg_wait;
                    r_d.hold   = cfg_hold;
                    // Turnaround depends on the latch line used by the previous access.
                    r_d.turn   = !req_write && (r_q.prev != KIND_DATA);
                    r_d.turn_len = (r_q.prev == KIND_CMD) ? {{PAD_W{1'b0}}, cfg_cle_dly}
                                                          : {{PAD_W{1'b0}}, cfg_ale_dly};
                    cnt_load = 1'b1;
                    if (req_write && (cfg_hiz != '0)) begin
                        r_d.st  = ST_HIZ;
                        cnt_val = cfg_hiz - 1'b1;
                    end else begin
                        r_d.st  = ST_SETUP;
                        cnt_val = cfg_setup;
                    end
                end
            end
            ST_HIZ: begin
                if (cnt_zero) begin
                    r_d.st   = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = r_q.setup;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    if (r_q.turn) begin
                        r_d.st  = ST_TURN;
                        cnt_val = r_q.turn_len;
                    end else begin
                        r_d.st  = ST_STROBE;
                        cnt_val = r_q.strobe;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero) begin
                    r_d.st   = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = r_q.strobe;
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    if (dev_wait_n) begin
                        r_d.st   = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = r_q.hold;
                        if (!r_q.write) begin
                            r_d.rbyte = dq_in;
                        end
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (dev_wait_n) begin
                    r_d.st   = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = r_q.hold;
                    if (!r_q.write) begin
                        r_d.rbyte = dq_in;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.kind  <= KIND_DATA;
            r_q.prev  <= KIND_DATA;
        end else begin
            r_q <= r_d;
        end
    end

    // Pin decode from the registered state.
    assign active    = (r_q.st != ST_IDLE) && (r_q.st != ST_DONE);
    assign strobe_on = (r_q.st == ST_STROBE) || (r_q.st == ST_WAIT);

    nand_bank_decode #(.NBANKS(NBANKS)) u_bank (
        .enable (active),
        .bank   (r_q.bank),
        .ce_n   (ce_n)
    );

    assign cle     = active && (r_q.kind == KIND_CMD);
    assign ale     = active && (r_q.kind == KIND_ADDR);
    assign re_n    = !(strobe_on && !r_q.write);
    assign we_n    = !(strobe_on && r_q.write);
    assign dq_oe   = active && r_q.write && (r_q.st != ST_HIZ);
    assign dq_out  = r_q.wbyte;
    assign rd_data = r_q.rbyte;
    assign done    = (r_q.st == ST_DONE);
    assign busy    = (r_q.st != ST_IDLE);
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker #(
    parameter int NBANKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [NBANKS-1:0] ce_n,
    input logic              cle,
    input logic              ale,
    input logic              re_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              dev_wait_n
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ce_n && re_n && we_n && !cle && !ale && !dq_oe));

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!re_n && !we_n));

    assert_read_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n && !dev_wait_n) |=> !re_n);

    assert_write_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !dev_wait_n) |=> !we_n);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&ce_n && re_n && we_n && !dq_oe));
endmodule

bind nand_cycle_seq nand_seq_checker #(.NBANKS(NBANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .ce_n       (ce_n),
    .cle        (cle),
    .ale        (ale),
    .re_n       (re_n),
    .we_n       (we_n),
    .dq_oe      (dq_oe),
    .dev_wait_n (dev_wait_n)
);

// File: tb/tb_nand_cycle_seq.sv
module tb_nand_cycle_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic       req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_byte = '0;
    logic [3:0] cfg_cle_dly = '0;
    logic [3:0] cfg_ale_dly = '0;
    logic [7:0] cfg_hiz = '0;
    logic [7:0] cfg_hold = '0;
    logic [7:0] cfg_wait = '0;
    logic [7:0] cfg_setup = '0;
    logic       dev_wait_n = 1'b1;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic [3:0] ce_n;
    logic       cle, ale, re_n, we_n, done, busy;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int last_kind = 2;      // reset behaves as if a data access came last
    logic [7:0] exp_rd = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    nand_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_bank(req_bank), .req_byte(req_byte),
        .cfg_cle_dly(cfg_cle_dly), .cfg_ale_dly(cfg_ale_dly), .cfg_hiz(cfg_hiz),
        .cfg_hold(cfg_hold), .cfg_wait(cfg_wait), .cfg_setup(cfg_setup),
        .dev_wait_n(dev_wait_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .ce_n(ce_n), .cle(cle), .ale(ale), .re_n(re_n), .we_n(we_n),
        .rd_data(rd_data), .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One access: the expected pin values of every cycle come from phase lengths
    // worked out from the requirements.
    task automatic access(input int kind, input bit wr, input int bank, input logic [7:0] wbyte,
                          input int hz, input int su, input int wt, input int hd,
                          input int cd, input int ad, input int extra, input logic [7:0] rbyte);
        int hzl, turn, pre, send, n;
        string stag;
        hzl  = wr ? hz : 0;                                       // R5
        turn = (!wr && last_kind != 2) ? ((last_kind == 0) ? cd + 1 : ad + 1) : 0;   // R8
        pre  = hzl + su + 1 + turn;                               // R4
        send = pre + wt + 1 + extra;                              // R6
        n    = send + hd + 1;                                     // R7

        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_write = wr; req_bank = 2'(bank);
        req_byte = wbyte; cfg_hiz = 8'(hz); cfg_setup = 8'(su); cfg_wait = 8'(wt);
        cfg_hold = 8'(hd); cfg_cle_dly = 4'(cd); cfg_ale_dly = 4'(ad);
        dev_wait_n = 1'b1; dq_in = rbyte;

        for (int idx = 0; idx <= n + 1; idx++) begin
            bit act_c, in_hiz, in_str;
            @(negedge clk);
            act_c  = idx < n;
            in_hiz = idx < hzl;
            in_str = (idx >= pre) && (idx < send);
            if (!wr && idx == send) exp_rd = rbyte;
            if (idx < pre) stag = (turn > 0 && idx >= pre - turn) ? "R8" : "R4";
            else if (idx < send) stag = "R6";
            else stag = "R7";

            chk("R11", "busy", busy, idx <= n);
            chk("R2", "ce_n", ce_n, act_c ? (~(4'b1 << bank) & 4'hF) : 4'hF);
            chk("R3", "cle", cle, act_c && kind == 0);
            chk("R3", "ale", ale, act_c && kind == 1);
            chk(stag, "re_n", re_n, !(in_str && !wr));
            chk(stag, "we_n", we_n, !(in_str && wr));
            chk("R5", "dq_oe", dq_oe, wr && act_c && !in_hiz);
            if (wr && act_c && !in_hiz) chk("R9", "dq_out", dq_out, wbyte);
            chk("R9", "rd_data", rd_data, exp_rd);
            chk("R10 R12", "done", done, idx == n);

            // R12: timing inputs scrambled right after acceptance.
            if (idx == 0) begin
                req_valid = 1'b0;
                cfg_hiz = ~cfg_hiz; cfg_setup = ~cfg_setup; cfg_wait = ~cfg_wait;
                cfg_hold = ~cfg_hold; cfg_cle_dly = ~cfg_cle_dly; cfg_ale_dly = ~cfg_ale_dly;
            end
            // R11: a request while busy must be ignored.
            if (idx == 1) begin
                req_valid = 1'b1; req_byte = ~wbyte; req_bank = 2'(bank ^ 1);
                req_write = !wr; req_kind = 2'((kind + 1) % 3);
            end
            if (idx == 2) req_valid = 1'b0;
            dev_wait_n = !((idx >= send - extra - 1) && (idx < send - 1));
            dq_in = (idx < send) ? rbyte : ~rbyte;
        end
        dev_wait_n = 1'b1;
        last_kind = kind;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and just after release
        chk("R1", "ce_n", ce_n, 4'hF);
        chk("R1", "strobes", {re_n, we_n}, 2'b11);
        chk("R1", "cle/ale/oe", {cle, ale, dq_oe}, 3'b000);
        chk("R1", "done/busy", {done, busy}, 2'b00);
        chk("R1", "rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after release", {ce_n, re_n, we_n, busy}, 7'b1111110);

        access(0, 1'b1, 0, 8'h70,   0,   0,   0,   0,  3, 2, 0, 8'h11);
        access(2, 1'b0, 2, 8'h00,   9,   1,   2,   1, 15, 4, 0, 8'hC3);
        access(1, 1'b1, 1, 8'h5A,   3,   2,   1,   2,  1, 1, 2, 8'h22);
        access(2, 1'b0, 3, 8'h00,   0,   0,   0, 255,  0, 5, 3, 8'h3C);
        access(3, 1'b0, 0, 8'h00,   4,   4,   0,   0,  7, 7, 1, 8'hA5);
        access(2, 1'b1, 3, 8'hFF, 255, 255, 255,   0,  2, 2, 0, 8'h33);
        access(2, 1'b1, 2, 8'h01,   1,   0,   0,   0,  0, 0, 5, 8'h44);

        summary();
        $finish;
    end
endmodule